// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block lets synchronous logic use an external asynchronous static RAM holding 8192 words of 9 bits. The host raises a request with an address, a direction bit and write data. The controller then performs one complete read or write on the memory pins and reports completion through a ready signal. Read results are held in a register on the host side.

Every phase of a memory cycle lasts a whole number of clocks, and each of those counts is a parameter. The user picks the counts from the memory's timing table for the chosen speed grade and clock period. The defaults suit the fastest grade at a 5 ns clock: three clocks for address-to-data, two for output-enable-to-data, two for the write pulse and two for data setup.

The memory has two chip selects, one active low and one active high. The controller drives both from separate flops and always keeps them in agreement. During writes it holds output enable high, so the shorter write pulse is allowed and the memory never drives the shared bus. The controller's own bus drivers turn on one clock after write enable falls. They turn off one clock after write enable rises.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever no cycle is in progress, host_ready is 1. mem_ce_n, mem_oe_n and mem_we_n are 1, mem_ce2 is 0, and the controller leaves mem_dq undriven (high impedance).
- R2: mem_ce2 is always the inverse of mem_ce_n. The memory is selected exactly when mem_ce_n is 0.
- R3: A read (host_we = 0) selects the memory with mem_we_n = 1 and mem_oe_n = 0 for RD_LEN = max(ADDR_WAIT, OE_WAIT) clocks. It captures mem_dq at the end of the last of those clocks. In the next clock host_ready returns to 1 and host_rdata holds the captured word.
- R4: A write (host_we = 1) holds mem_we_n at 0 for WR_LEN = max(WE_PULSE, DATA_SETUP + 1) clocks, with mem_oe_n at 1 throughout.
- R5: The controller drives mem_dq only from the second clock of the write pulse until the clock after mem_we_n rises. In the first clock of the pulse, mem_dq is undriven.
- R6: While the controller drives mem_dq, the value is the write data latched at acceptance, and it stays stable. The memory therefore stores that word when mem_we_n rises.
- R7: mem_addr is the address latched at acceptance and does not change while the memory remains selected.
- R8: A request is taken only in a clock where host_ready is 1. A request held while host_ready is 0 has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request for one memory cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Word address |
| host_wdata | input | 9 | Write data |
| host_ready | output | 1 | Idle, able to take a request |
| host_rdata | output | 9 | Word from the last read |
| mem_addr | output | 13 | Memory address bus |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_ce2 | output | 1 | Memory select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq | inout | 9 | Bidirectional memory data bus |

## Verification
A request is accepted at the clock edge where host_req meets host_ready. The memory strobes change at that same edge. Read data is valid at host_rdata one edge after RD_LEN strobe clocks, when host_ready is back at 1. A written word is present in the memory model once mem_we_n rises, WR_LEN clocks after acceptance.

The bench samples at the falling edge. It counts the number of falling edges with each strobe low, checks mem_dq in the first and later clocks of the pulse, and compares the results against a queue of expected operations whenever host_ready rises.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WREL  = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_cmd_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len_m1,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len_m1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              drive_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] dq
);
    assign dq = drive_en ? wdata : {DATA_W{1'bz}};

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= dq;
        end
    end

    // R6: the driven word never changes while the drivers stay on
    p_dq_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (drive_en && $past(drive_en)) |-> $stable(wdata));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_WAIT  = 3,
    parameter int OE_WAIT    = 2,
    parameter int WE_PULSE   = 2,
    parameter int DATA_SETUP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int RD_LEN = imax(ADDR_WAIT, OE_WAIT);
    localparam int WR_LEN = imax(WE_PULSE, DATA_SETUP + 1);
    localparam int CNT_W  = cnt_width(imax(RD_LEN, WR_LEN));

    if (ADDR_WAIT < 1 || OE_WAIT < 1 || WE_PULSE < 1 || DATA_SETUP < 1) begin : g_bad_count
        $error("sram_ctrl: every wait count must be at least one clock");
    end

    ctl_state_e       state;
    host_cmd_t        cmd;
    logic             drv_en;
    logic             accept;
    logic             t_last;
    logic [CNT_W-1:0] t_len;

    assign host_ready = (state == ST_IDLE);
    assign accept     = host_ready && host_req;
    assign t_len      = host_we ? CNT_W'(WR_LEN - 1) : CNT_W'(RD_LEN - 1);
    assign mem_addr   = cmd.addr;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .len_m1 (t_len),
        .last   (t_last)
    );

    sram_dq_port u_dq (
        .clk      (clk),
        .rst      (rst),
        .drive_en (drv_en),
        .wdata    (cmd.wdata),
        .capture  ((state == ST_READ) && t_last),
        .rdata    (host_rdata),
        .dq       (mem_dq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cmd      <= '0;
            mem_ce_n <= 1'b1;
            mem_ce2  <= 1'b0;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            drv_en   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (host_req) begin
                        cmd.addr  <= host_addr;
                        cmd.wdata <= host_wdata;
                        mem_ce_n  <= 1'b0;
                        mem_ce2   <= 1'b1;
                        if (host_we) begin
                            mem_we_n <= 1'b0;
                            state    <= ST_WRITE;
                        end else begin
                            mem_oe_n <= 1'b0;
                            state    <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (t_last) begin
                        mem_ce_n <= 1'b1;
                        mem_ce2  <= 1'b0;
                        mem_oe_n <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    drv_en <= 1'b1;
                    if (t_last) begin
                        mem_we_n <= 1'b1;
                        state    <= ST_WREL;
                    end
                end
                default: begin
                    drv_en   <= 1'b0;
                    mem_ce_n <= 1'b1;
                    mem_ce2  <= 1'b0;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    // R2: the two selects always agree
    p_select_pair_r2: assert property (@(posedge clk) disable iff (rst)
        mem_ce2 == !mem_ce_n);

    // R3: output enable only in a selected read cycle
    p_oe_read_only_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    // R4: output enable stays high during the write pulse
    p_oe_high_write_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R5: own drivers only after write enable was already low
    p_drive_window_r5: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> $past(!mem_we_n));

    // R7: address held while the memory stays selected
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R8: nothing starts while busy
    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (!host_ready && $past(!host_ready) && $past(mem_ce_n)) |-> mem_ce_n);

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
    import sram_ctrl_pkg::*;

    localparam int RD_LEN = 3;
    localparam int WR_LEN = 3;

    typedef struct {
        bit                is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } op_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              host_ready;
    logic [DATA_W-1:0] host_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ce_n, mem_ce2, mem_oe_n, mem_we_n;
    wire  [DATA_W-1:0] mem_dq;

    int checks = 0;
    int errors = 0;
    int pops   = 0;
    bit done   = 0;
    op_t exp_q[$];

    always #2.5 clk = ~clk;

    sram_ctrl dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    // memory model
    logic [DATA_W-1:0] mem [int];
    logic              m_sel, m_drv;
    logic [DATA_W-1:0] m_out;

    function automatic logic [DATA_W-1:0] init_val(input logic [ADDR_W-1:0] a);
        return a[DATA_W-1:0] ^ 9'h0A5;
    endfunction

    function automatic logic [DATA_W-1:0] peek(input logic [ADDR_W-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return init_val(a);
    endfunction

    always_comb begin
        m_sel = !mem_ce_n && mem_ce2;
        m_drv = m_sel && !mem_oe_n && mem_we_n;
        m_out = peek(mem_addr);
    end
    assign mem_dq = m_drv ? m_out : {DATA_W{1'bz}};

    always @(posedge mem_we_n) begin
        if (!rst && m_sel) mem[int'(mem_addr)] = mem_dq;
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard
    int  oe_cnt = 0, we_cnt = 0;
    bit  prev_ready = 1'b0;
    bit  oe_in_we = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_oe_n) oe_cnt++;
            if (!mem_we_n) begin
                we_cnt++;
                if (!mem_oe_n) oe_in_we = 1'b1;
                if (we_cnt == 1)
                    check(mem_dq === {DATA_W{1'bz}}, "R5 bus idle first pulse clock", 16'(mem_dq), 16'h1ff);
                else if (exp_q.size() > 0)
                    check(mem_dq === exp_q[0].data, "R6 driven data", 16'(mem_dq), 16'(exp_q[0].data));
            end
            if (!mem_ce_n && exp_q.size() > 0 && mem_addr !== exp_q[0].addr)
                check(0, "R7 address", 16'(mem_addr), 16'(exp_q[0].addr));
            if (host_ready && !prev_ready && exp_q.size() > 0) begin
                op_t it;
                it = exp_q.pop_front();
                pops++;
                check(mem_ce2 === !mem_ce_n && mem_ce_n === 1'b1, "R2 selects released", {mem_ce_n, mem_ce2}, 16'h2);
                if (it.is_wr) begin
                    check(we_cnt == WR_LEN, "R4 write pulse length", 16'(we_cnt), 16'(WR_LEN));
                    check(!oe_in_we, "R4 oe high in write", 16'(oe_in_we), 16'h0);
                    check(peek(it.addr) === it.data, "R6 stored word", 16'(peek(it.addr)), 16'(it.data));
                end else begin
                    check(oe_cnt == RD_LEN, "R3 read strobe length", 16'(oe_cnt), 16'(RD_LEN));
                    check(host_rdata === it.data, "R3 read data", 16'(host_rdata), 16'(it.data));
                end
                oe_cnt = 0; we_cnt = 0; oe_in_we = 1'b0;
            end
            prev_ready = host_ready;
        end
    end

    task automatic do_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        op_t it;
        while (!host_ready) @(negedge clk);
        it.is_wr = wr; it.addr = a; it.data = wr ? d : peek(a);
        exp_q.push_back(it);
        host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(host_ready === 1'b1, "R1 ready", 16'(host_ready), 16'h1);
        check({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n} === 4'b1011, "R1 strobes idle",
              16'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}), 16'hb);
        check(mem_dq === {DATA_W{1'bz}}, "R1 bus released", 16'(mem_dq), 16'h1ff);

        do_op(1, 13'h0000, 9'h1FF);
        do_op(1, 13'h1FFF, 9'h000);
        do_op(1, 13'h0155, 9'h155);
        do_op(1, 13'h0AAA, 9'h0AA);
        do_op(0, 13'h0000, 9'h0);
        do_op(0, 13'h1FFF, 9'h0);
        do_op(0, 13'h0155, 9'h0);
        do_op(0, 13'h0AAA, 9'h0);
        do_op(0, 13'h0777, 9'h0);
        do_op(1, 13'h0155, 9'h03C);
        do_op(0, 13'h0155, 9'h0);

        // R8: request held while busy is ignored
        begin
            op_t it;
            while (!host_ready) @(negedge clk);
            it.is_wr = 0; it.addr = 13'h0042; it.data = peek(13'h0042);
            exp_q.push_back(it);
            host_req = 1'b1; host_we = 1'b0; host_addr = 13'h0042;
            @(negedge clk);
            host_we = 1'b1; host_addr = 13'h0123; host_wdata = 9'h111;
            @(negedge clk);
            host_req = 1'b0;
            while (!host_ready) @(negedge clk);
            repeat (3) @(negedge clk);
            check(pops == 12, "R8 single cycle taken", 16'(pops), 16'd12);
            check(peek(13'h0123) === init_val(13'h0123), "R8 busy write ignored",
                  16'(peek(13'h0123)), 16'(init_val(13'h0123)));
        end
        do_op(0, 13'h0123, 9'h0);

        // R1: idle again after traffic
        @(negedge clk);
        check({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n} === 4'b1011 && mem_dq === {DATA_W{1'bz}},
              "R1 idle after traffic", 16'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}), 16'hb);
        check(exp_q.size() == 0, "R3 all ops completed", 16'(exp_q.size()), 16'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule